// File: doc/BRIEF.md
# Eye-Monitor Supply Scaling Controller

This controller trims the supply of an optical receiver front-end down to the lowest level that still meets a target error rate. Every clock it receives one decision from the data comparator and one from a parallel eye-monitor comparator. The eye-monitor comparator samples on the same clock phase but slices with an extra voltage margin. A mismatch between the two shows that the eye is closing before any real bit error occurs.

Only the worst-case intersymbol pattern is scored. That pattern is a 0 followed by a 1, and the mismatch is taken on the 1. Mismatches on the qualifying bits are counted over a programmable window of bits. At the end of each window a 6-bit supply DAC code is stepped down when there were no errors and stepped up when the count is above a programmable limit. For any count in between the code is held. This dead zone keeps the loop from dithering without needing a long averaging counter. A one-cycle strobe marks every change of the code.

Top module: `eye_supply_ctrl`

## Requirements
- R1: While reset is asserted, and at release, `supply_code` equals `RESET_CODE` (default 63) and `supply_upd` is 0.
- R2: A bit is scored only when the previous sampled data bit was 0 and the current data bit is 1. It counts as an error only when `mon_bit` differs from `data_bit` on that bit. Mismatches on any other pattern have no effect on the code.
- R3: A window spans `win_len` enabled bits, and a `win_len` of 0 acts as 1. The decision takes effect at the clock edge that samples the window's last bit. The error count then restarts from zero.
- R4: A window with zero errors lowers `supply_code` by exactly one.
- R5: A window whose error count is greater than `err_limit` raises `supply_code` by exactly one.
- R6: A window whose error count is between 1 and `err_limit` inclusive leaves `supply_code` unchanged, and no strobe is given.
- R7: The code saturates: no step below 0 and none above 63. A saturated decision gives no strobe.
- R8: `supply_upd` is high for exactly the one cycle that follows each change of `supply_code` and is low at all other times.
- R9: While `enable` is low, `supply_code` is frozen and the bit counter, the error counter and the pair history are cleared. A fresh window starts when `enable` returns.
- R10: The first enabled bit after reset or after `enable` returns has no predecessor, so it is never scored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Adaptation enable; low freezes the code |
| data_bit | input | 1 | Data comparator decision |
| mon_bit | input | 1 | Eye-monitor comparator decision, same phase |
| win_len | input | WIN_W (12) | Bits per evaluation window |
| err_limit | input | WIN_W (12) | Largest error count that still holds the code |
| supply_code | output | 6 | Front-end supply DAC code |
| supply_upd | output | 1 | One-cycle strobe on each code change |

## Verification
The pair history, the counters and the code are all registered. A stimulus applied before a clock edge therefore reaches `supply_code` and `supply_upd` at that same edge, but only when the edge samples the window's last bit; on every other edge the outputs do not move. The bench drives inputs on the falling edge and advances its behavioural model on the rising edge. It compares both outputs at the next falling edge, which makes every result due exactly one edge after its stimulus. Directed phases cover the zero-error, dead-zone and over-limit windows, non-qualifying mismatches, disable, and both saturation ends.

// File: rtl/eye_ctrl_pkg.sv
package eye_ctrl_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_DOWN = 2'd1,
    STEP_UP   = 2'd2
  } step_e;
endpackage

// File: rtl/eye_pair_qual.sv
// Scores the worst-case 0->1 transition: flags a mismatch on the rising bit.
module eye_pair_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic data_bit,
  input  logic mon_bit,
  output logic err_hit
);
  logic prev_q, prev_d;
  logic pvld_q, pvld_d;

  always_comb begin
    prev_d = prev_q;
    pvld_d = pvld_q;
    if (!en) begin
      pvld_d = 1'b0;
    end else begin
      prev_d = data_bit;
      pvld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pvld_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      pvld_q <= pvld_d;
    end
  end

  assign err_hit = en & pvld_q & ~prev_q & data_bit & (data_bit ^ mon_bit);

  // R10: the cycle after a disabled cycle never scores an error
  p_no_pred_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> !err_hit);
endmodule

// File: rtl/eye_err_window.sv
// Counts bits and qualified errors over a window and picks a step direction.
module eye_err_window
  import eye_ctrl_pkg::*;
#(
  parameter int WIN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             err_hit,
  input  logic [WIN_W-1:0] win_len,
  input  logic [WIN_W-1:0] err_limit,
  output logic             win_last,
  output step_e            step
);
  localparam int CW = WIN_W + 1;

  logic [WIN_W-1:0] cnt_q, cnt_d;
  logic [WIN_W-1:0] err_q, err_d;
  logic [CW-1:0]    err_tot;

  assign err_tot  = {1'b0, err_q} + CW'(err_hit);
  assign win_last = ({1'b0, cnt_q} + CW'(1)) >= {1'b0, win_len};

  always_comb begin
    if (err_tot == '0)
      step = STEP_DOWN;
    else if (err_tot > {1'b0, err_limit})
      step = STEP_UP;
    else
      step = STEP_HOLD;
  end

  always_comb begin
    cnt_d = cnt_q;
    err_d = err_q;
    if (!en) begin
      cnt_d = '0;
      err_d = '0;
    end else if (win_last) begin
      cnt_d = '0;
      err_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
      err_d = err_tot[WIN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  // R2: one error at most per scored bit, so errors never outnumber bits
  p_err_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err_q <= cnt_q);
  // R9: disabled cycle empties both counters
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> (cnt_q == '0 && err_q == '0));
endmodule

// File: rtl/eye_code_step.sv
// Holds the saturating supply code and emits the change strobe.
module eye_code_step
  import eye_ctrl_pkg::*;
#(
  parameter int CODE_W     = 6,
  parameter int RESET_CODE = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              win_last,
  input  step_e             step,
  output logic [CODE_W-1:0] code,
  output logic              upd
);
  localparam logic [CODE_W-1:0] CODE_MAX  = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_INIT = CODE_W'(RESET_CODE);

  logic [CODE_W-1:0] code_q, code_d;
  logic              upd_q, upd_d;

  always_comb begin
    code_d = code_q;
    upd_d  = 1'b0;
    if (en && win_last) begin
      unique case (step)
        STEP_DOWN: if (code_q != '0) begin
          code_d = code_q - 1'b1;
          upd_d  = 1'b1;
        end
        STEP_UP: if (code_q != CODE_MAX) begin
          code_d = code_q + 1'b1;
          upd_d  = 1'b1;
        end
        default: code_d = code_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= CODE_INIT;
      upd_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      upd_q  <= upd_d;
    end
  end

  assign code = code_q;
  assign upd  = upd_q;

  // R8: strobe if and only if the code moved on the last edge
  p_strobe_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q == (code_q != $past(code_q)));
  // R4: a decision never moves the code by more than one LSB
  p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == $past(code_q)) || (code_q == $past(code_q) + 1'b1) ||
    (code_q == $past(code_q) - 1'b1));
  // R9: code frozen while disabled
  p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> $stable(code_q));
  // R7: no wrap from the lower end
  p_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == '0) |=> (code_q != CODE_MAX));
endmodule

// File: rtl/eye_supply_ctrl.sv
module eye_supply_ctrl
  import eye_ctrl_pkg::*;
#(
  parameter int WIN_W      = 12,
  parameter int CODE_W     = 6,
  parameter int RESET_CODE = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              data_bit,
  input  logic              mon_bit,
  input  logic [WIN_W-1:0]  win_len,
  input  logic [WIN_W-1:0]  err_limit,
  output logic [CODE_W-1:0] supply_code,
  output logic              supply_upd
);
  logic  err_hit;
  logic  win_last;
  step_e step;

  eye_pair_qual u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (enable),
    .data_bit (data_bit),
    .mon_bit  (mon_bit),
    .err_hit  (err_hit)
  );

  eye_err_window #(.WIN_W(WIN_W)) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (enable),
    .err_hit   (err_hit),
    .win_len   (win_len),
    .err_limit (err_limit),
    .win_last  (win_last),
    .step      (step)
  );

  eye_code_step #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_step (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (enable),
    .win_last (win_last),
    .step     (step),
    .code     (supply_code),
    .upd      (supply_upd)
  );
endmodule

// File: tb/eye_supply_ctrl_test.sv
module eye_supply_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic        data_bit;
  logic        mon_bit;
  logic [11:0] win_len;
  logic [11:0] err_limit;
  logic [5:0]  supply_code;
  logic        supply_upd;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  // behavioural reference state
  int m_code, m_cnt, m_err, m_prev, m_pvld, m_upd;

  always #2 clk = ~clk;  // 250 MHz

  eye_supply_ctrl uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .data_bit(data_bit),
    .mon_bit(mon_bit), .win_len(win_len), .err_limit(err_limit),
    .supply_code(supply_code), .supply_upd(supply_upd)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // one bit: drive at falling edge, model at rising edge, compare at next falling edge
  task automatic bit_step(input int d, input int m, input int e, input string tag);
    int q, er, wl;
    data_bit = d[0];
    mon_bit  = m[0];
    enable   = e[0];
    @(posedge clk);
    m_upd = 0;
    if (e == 0) begin
      m_pvld = 0; m_cnt = 0; m_err = 0;
    end else begin
      q  = (m_pvld == 1 && m_prev == 0 && d == 1) ? 1 : 0;
      er = m_err + ((q == 1 && d != m) ? 1 : 0);
      wl = (win_len == 0) ? 1 : int'(win_len);
      if (m_cnt + 1 >= wl) begin
        if (er == 0) begin
          if (m_code > 0) begin m_code--; m_upd = 1; end
        end else if (er > int'(err_limit)) begin
          if (m_code < 63) begin m_code++; m_upd = 1; end
        end
        m_cnt = 0; m_err = 0;
      end else begin
        m_cnt++; m_err = er;
      end
      m_prev = d; m_pvld = 1;
    end
    @(negedge clk);
    check(tag, supply_code, m_code);
    check("R8 strobe", supply_upd, m_upd);
  endtask

  initial begin
    rst_n = 1'b0; enable = 1'b0; data_bit = 1'b0; mon_bit = 1'b0;
    win_len = 12'd4; err_limit = 12'd1;
    m_code = 63; m_cnt = 0; m_err = 0; m_prev = 0; m_pvld = 0; m_upd = 0;
    repeat (3) @(negedge clk);
    check("R1 reset code", supply_code, 63);
    check("R1 reset strobe", supply_upd, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", supply_code, 63);

    // R4: clean alternating data, three windows
    for (int w = 0; w < 3; w++) begin
      bit_step(0, 0, 1, "R4"); bit_step(1, 1, 1, "R4");
      bit_step(0, 0, 1, "R4"); bit_step(1, 1, 1, "R4");
    end
    check("R4 after three clean windows", supply_code, 60);

    // R2: mismatches only on non-qualifying bits
    for (int w = 0; w < 2; w++) begin
      bit_step(0, 1, 1, "R2"); bit_step(1, 1, 1, "R2");
      bit_step(1, 0, 1, "R2"); bit_step(1, 0, 1, "R2");
    end
    check("R2 non-qualifying mismatches ignored", supply_code, 58);

    // R6: one error per window, limit 1 -> hold
    for (int w = 0; w < 2; w++) begin
      bit_step(0, 0, 1, "R6"); bit_step(1, 0, 1, "R6");
      bit_step(0, 0, 1, "R6"); bit_step(1, 1, 1, "R6");
    end
    check("R6 dead zone hold", supply_code, 58);

    // R5: two errors > limit 1 -> raise
    bit_step(0, 0, 1, "R5"); bit_step(1, 0, 1, "R5");
    bit_step(0, 0, 1, "R5"); bit_step(1, 0, 1, "R5");
    check("R5 over limit raise", supply_code, 59);

    // R9: disabled with qualifying mismatches -> frozen
    for (int i = 0; i < 8; i++) bit_step(i % 2, 0, 0, "R9");
    bit_step(0, 0, 0, "R9");
    check("R9 frozen while disabled", supply_code, 59);

    // R10: first enabled bit after disable is not paired with the old 0
    bit_step(1, 0, 1, "R10"); bit_step(1, 1, 1, "R10");
    bit_step(1, 1, 1, "R10"); bit_step(1, 1, 1, "R10");
    check("R10 no predecessor", supply_code, 58);

    // R3 / R7: win_len 0 acts as 1, run down to floor
    win_len = 12'd0; err_limit = 12'd0;
    for (int i = 0; i < 70; i++) bit_step(1, 1, 1, "R3 R7 down");
    check("R7 floor", supply_code, 0);

    // R7 / R5: limit 0, one error per two-bit window, run up to ceiling
    win_len = 12'd2;
    for (int w = 0; w < 70; w++) begin
      bit_step(0, 0, 1, "R7 up"); bit_step(1, 0, 1, "R7 up");
    end
    check("R7 ceiling", supply_code, 63);
    check("R8 no strobe at ceiling", supply_upd, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule